// File: doc/BRIEF.md
# DMA Physical Address Former with Page Registers

This block keeps the page storage of one DMA controller: eight byte-wide page slots and, optionally, eight byte-wide high-page slots. From these it builds the 32-bit physical address of a transfer for the channel that the counter logic selects. The counter logic supplies the channel's 16-bit current address. The block adds the page byte as bits 23:16 and the high-page byte as bits 31:24.

Software reaches the slots through a simple register port. The port has a write strobe, a read strobe, a bank select, a byte/word size flag and a 3-bit slot index. Four of the eight page slots feed the address former. The other four are plain storage. A parameter selects the 16-bit controller flavour. In that flavour the current address is shifted left by one bit and the page byte loses its lowest bit.

Top module: `dmapg_addr_unit`

## Requirements
- R1: The channel index picks the page slot used for the address: channel 0 uses slot 7, channel 1 uses slot 3, channel 2 uses slot 1 and channel 3 uses slot 2. The high-page slot with the same number is used alongside it.
- R2: With WIDE16=0, phys_addr equals {high slot, page slot, cur_addr}. It is combinational in the register contents, chan_idx and cur_addr.
- R3: With WIDE16=1, phys_addr equals {high slot, page slot with bit 0 cleared, 16'h0} OR (cur_addr shifted left by one).
- R4: A write with sel_hi=0 and is_word=0 stores wdata[7:0] in page slot reg_idx. The same write clears high-page slot reg_idx to zero, and the result is visible after the clock edge.
- R5: A write with sel_hi=0 and is_word=1 stores wdata[7:0] in slot n=reg_idx and wdata[15:8] in slot (n+1) mod 8, both in the same cycle. It clears both matching high-page slots.
- R6: A read with sel_hi=0 sets rd_valid=1. A byte read returns {8'h00, page[n]}. A word read returns {page[(n+1) mod 8], page[n]}.
- R7: A write with sel_hi=1 and is_word=0 stores wdata[7:0] in high-page slot reg_idx and leaves every page slot unchanged. A byte read with sel_hi=1 returns {8'h00, high[n]} with rd_valid=1.
- R8: With sel_hi=1 and is_word=1, a write changes no slot. A read of that kind returns rd_valid=0 and rdata=16'h0000.
- R9: Page slots 0, 4, 5 and 6 are read/write storage only. Writing them leaves phys_addr unchanged for every channel.
- R10: After power-on reset every page and high-page slot reads zero. No slot changes in a cycle without wr_en.
- R11: With HAS_HIPAGE=0, high-page writes are ignored and high-page reads return rd_valid=0. phys_addr[31:24] is zero, and page accesses behave as in R4 to R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset, clears all slots |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| sel_hi | input | 1 | 1 selects the high-page bank, 0 the page bank |
| is_word | input | 1 | 1 for a 16-bit access, 0 for a byte access |
| reg_idx | input | 3 | Slot index of the access |
| wdata | input | 16 | Write data, low byte to slot n, high byte to slot n+1 |
| rdata | output | 16 | Read data, zero when rd_valid is low |
| rd_valid | output | 1 | Read returns data |
| chan_idx | input | 2 | Channel whose address is formed |
| cur_addr | input | 16 | Channel's current address from the counter logic |
| phys_addr | output | 32 | Formed physical address |

## Verification
The bench builds three copies of the block that share one stimulus stream. The first is the 8-bit flavour with high pages and the second is the 16-bit flavour with high pages. Both 16-bit effects come within reach with the second copy: the shifted current address and the page bit that is cleared even when software writes 0xFF. The third copy is the 8-bit flavour without high pages, which shows that high-bank traffic is dropped and that address bits 31:24 stay clear. Because all three see the same writes, a mapping or clearing error in one flavour shows up as a mismatch against a model shared by all three.

// File: rtl/dmapg_addr_unit.sv
module dmapg_addr_unit #(
  parameter bit WIDE16     = 1'b0,
  parameter bit HAS_HIPAGE = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic        sel_hi,
  input  logic        is_word,
  input  logic [2:0]  reg_idx,
  input  logic [15:0] wdata,
  output logic [15:0] rdata,
  output logic        rd_valid,
  input  logic [1:0]  chan_idx,
  input  logic [15:0] cur_addr,
  output logic [31:0] phys_addr
);
  localparam int SLOTS = 8;

  logic [SLOTS-1:0][7:0] pg_q, hi_q;
  logic [2:0]  nxt_idx, slot;
  logic [7:0]  pg_sel, hi_sel;
  logic [31:0] off;

  assign nxt_idx = reg_idx + 3'd1;

  always_comb begin
    case (chan_idx)
      2'd0:    slot = 3'd7;
      2'd1:    slot = 3'd3;
      2'd2:    slot = 3'd1;
      default: slot = 3'd2;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pg_q <= '0;
      hi_q <= '0;
    end else if (wr_en) begin
      if (!sel_hi) begin
        pg_q[reg_idx] <= wdata[7:0];
        hi_q[reg_idx] <= 8'h00;
        if (is_word) begin
          pg_q[nxt_idx] <= wdata[15:8];
          hi_q[nxt_idx] <= 8'h00;
        end
      end else if (HAS_HIPAGE && !is_word) begin
        hi_q[reg_idx] <= wdata[7:0];
      end
    end
  end

  assign rd_valid = rd_en && !(sel_hi && (is_word || !HAS_HIPAGE));

  always_comb begin
    rdata = 16'h0000;
    if (rd_valid) begin
      if (sel_hi)       rdata = {8'h00, hi_q[reg_idx]};
      else if (is_word) rdata = {pg_q[nxt_idx], pg_q[reg_idx]};
      else              rdata = {8'h00, pg_q[reg_idx]};
    end
  end

  assign pg_sel = pg_q[slot] & ~{7'h00, WIDE16};
  assign hi_sel = HAS_HIPAGE ? hi_q[slot] : 8'h00;

  generate
    if (WIDE16) begin : g_w16
      assign off = {15'h0000, cur_addr, 1'b0};
    end else begin : g_w8
      assign off = {16'h0000, cur_addr};
    end
  endgenerate

  assign phys_addr = {hi_sel, pg_sel, 16'h0000} | off;

  assert_page_wr_clears_hi_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !sel_hi |=> hi_q[$past(reg_idx)] == 8'h00);

  assert_word_upper_byte_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !sel_hi && is_word |=> pg_q[$past(nxt_idx)] == $past(wdata[15:8]));

  assert_hi_wr_keeps_page_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && sel_hi |=> $stable(pg_q));

  assert_hi_word_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && sel_hi && is_word |=> $stable(hi_q));

  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(pg_q) && $stable(hi_q));
endmodule

// File: tb/dmapg_addr_unit_tb.sv
`timescale 1ns/1ps
module dmapg_addr_unit_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0, sel_hi = 1'b0, is_word = 1'b0;
  logic [2:0]  reg_idx = '0;
  logic [15:0] wdata = '0, cur_addr = '0;
  logic [1:0]  chan_idx = '0;
  logic [15:0] rd0, rd1, rd2;
  logic        rv0, rv1, rv2;
  logic [31:0] pa0, pa1, pa2;
  logic [7:0]  pg_m [8];
  logic [7:0]  hi_m [8];
  int nvec = 0, nerr = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dmapg_addr_unit dut_i (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .sel_hi(sel_hi), .is_word(is_word), .reg_idx(reg_idx), .wdata(wdata),
    .rdata(rd0), .rd_valid(rv0), .chan_idx(chan_idx), .cur_addr(cur_addr), .phys_addr(pa0));
  dmapg_addr_unit #(.WIDE16(1'b1), .HAS_HIPAGE(1'b1)) dut_w16_i (.clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .rd_en(rd_en), .sel_hi(sel_hi), .is_word(is_word), .reg_idx(reg_idx),
    .wdata(wdata), .rdata(rd1), .rd_valid(rv1), .chan_idx(chan_idx), .cur_addr(cur_addr),
    .phys_addr(pa1));
  dmapg_addr_unit #(.WIDE16(1'b0), .HAS_HIPAGE(1'b0)) dut_nohi_i (.clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .rd_en(rd_en), .sel_hi(sel_hi), .is_word(is_word), .reg_idx(reg_idx),
    .wdata(wdata), .rdata(rd2), .rd_valid(rv2), .chan_idx(chan_idx), .cur_addr(cur_addr),
    .phys_addr(pa2));

  function automatic logic [31:0] exp_addr(bit w16, bit hh, logic [1:0] ch, logic [15:0] cur);
    logic [2:0] s;
    logic [7:0] p, h;
    case (ch)
      2'd0: s = 3'd7;
      2'd1: s = 3'd3;
      2'd2: s = 3'd1;
      default: s = 3'd2;
    endcase
    p = pg_m[s];
    if (w16) p[0] = 1'b0;
    h = hh ? hi_m[s] : 8'h00;
    return {h, p, 16'h0} | (w16 ? {15'h0, cur, 1'b0} : {16'h0, cur});
  endfunction

  function automatic logic [16:0] exp_rd(bit hh, bit sel, bit word, logic [2:0] idx);
    if (sel) begin
      if (word || !hh) return 17'h0;
      return {1'b1, 8'h00, hi_m[idx]};
    end
    if (word) return {1'b1, pg_m[idx + 3'd1], pg_m[idx]};
    return {1'b1, 8'h00, pg_m[idx]};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(bit sel, bit word, logic [2:0] idx, logic [15:0] d);
    @(negedge clk);
    sel_hi = sel; is_word = word; reg_idx = idx; wdata = d; wr_en = 1'b1; rd_en = 1'b0;
    @(posedge clk);
    #1;
    wr_en = 1'b0;
    if (!sel) begin
      pg_m[idx] = d[7:0]; hi_m[idx] = 8'h00;
      if (word) begin pg_m[idx + 3'd1] = d[15:8]; hi_m[idx + 3'd1] = 8'h00; end
    end else if (!word) begin
      hi_m[idx] = d[7:0];
    end
  endtask

  task automatic probe(string tag, logic [1:0] ch, logic [15:0] cur, bit sel, bit word,
                       logic [2:0] idx);
    string rt;
    @(negedge clk);
    chan_idx = ch; cur_addr = cur; sel_hi = sel; is_word = word; reg_idx = idx; rd_en = 1'b1;
    #1;
    rt = sel ? (word ? "R8" : "R7") : "R6";
    chk({tag, " addr8 R2"},  pa0, exp_addr(1'b0, 1'b1, ch, cur));
    chk({tag, " addr16 R3"}, pa1, exp_addr(1'b1, 1'b1, ch, cur));
    chk({tag, " nohi R11"},  pa2, exp_addr(1'b0, 1'b0, ch, cur));
    chk({tag, " read ", rt},      {15'h0, rv0, rd0}, {15'h0, exp_rd(1'b1, sel, word, idx)});
    chk({tag, " read16 ", rt},    {15'h0, rv1, rd1}, {15'h0, exp_rd(1'b1, sel, word, idx)});
    chk({tag, " readnohi R11"},   {15'h0, rv2, rd2}, {15'h0, exp_rd(1'b0, sel, word, idx)});
    rd_en = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog R10 actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'd4711);
    for (int i = 0; i < 8; i++) begin pg_m[i] = 8'h00; hi_m[i] = 8'h00; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < 8; i++) probe("reset R10", 2'(i), 16'h1234, 1'b0, 1'b0, 3'(i));
    probe("reset hi R10", 2'd0, 16'hFFFF, 1'b1, 1'b0, 3'd7);

    wr(1'b0, 1'b0, 3'd7, 16'h00A5);
    wr(1'b1, 1'b0, 3'd7, 16'h005C);
    probe("chan0 R1", 2'd0, 16'h8001, 1'b1, 1'b0, 3'd7);
    wr(1'b0, 1'b0, 3'd7, 16'h003C);
    probe("hi cleared R4", 2'd0, 16'h8001, 1'b1, 1'b0, 3'd7);

    wr(1'b0, 1'b0, 3'd3, 16'h0013);
    wr(1'b0, 1'b0, 3'd1, 16'h0021);
    wr(1'b0, 1'b0, 3'd2, 16'h00FF);
    wr(1'b1, 1'b0, 3'd2, 16'h0077);
    probe("chan1 R1", 2'd1, 16'h0F0F, 1'b0, 1'b0, 3'd3);
    probe("chan2 R1", 2'd2, 16'hF0F0, 1'b0, 1'b0, 3'd1);
    probe("page bit0 R3", 2'd3, 16'hFFFF, 1'b1, 1'b0, 3'd2);

    wr(1'b1, 1'b0, 3'd0, 16'h0011);
    wr(1'b1, 1'b0, 3'd7, 16'h0022);
    wr(1'b0, 1'b1, 3'd7, 16'hBEEF);
    probe("word wrap R5", 2'd0, 16'h0000, 1'b0, 1'b1, 3'd7);
    probe("word hi0 R5", 2'd0, 16'h0000, 1'b1, 1'b0, 3'd0);
    probe("word hi7 R5", 2'd0, 16'h0000, 1'b1, 1'b0, 3'd7);

    wr(1'b1, 1'b0, 3'd3, 16'h0044);
    wr(1'b1, 1'b1, 3'd3, 16'h9999);
    probe("hi word wr R8", 2'd1, 16'h0001, 1'b1, 1'b0, 3'd3);
    probe("hi word rd R8", 2'd1, 16'h0001, 1'b1, 1'b1, 3'd3);

    for (int s = 0; s < 4; s++) begin
      wr(1'b0, 1'b0, (s == 0) ? 3'd0 : 3'(s + 3), 16'h00E0 + 16'(s));
      for (int c = 0; c < 4; c++) probe("scratch R9", 2'(c), 16'h5A5A, 1'b0, 1'b0, 3'd4);
    end

    for (int i = 0; i < 600; i++) begin
      if ($urandom_range(1, 0) == 0)
        wr(1'($urandom), ($urandom_range(3, 0) == 0), 3'($urandom), 16'($urandom));
      else
        probe("random R6", 2'($urandom), 16'($urandom), 1'($urandom), 1'($urandom), 3'($urandom));
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule